// File: doc/BRIEF.md
# Thirty-Two-Bit ALU with Operand Steering

This block is the execute stage of a small register-based processor. It takes the value read from the source register, the value read from the second register, the instruction's immediate field, a register/immediate select bit, a shift-instruction flag and a 4-bit function code. From these it produces a registered 32-bit result, a write-enable for the register file and a signed-overflow flag. There is one ripple adder/subtractor, one ripple magnitude comparator and one shifter. Add and subtract share the adder. Bitwise AND, OR, XOR and NOT work on every bit position.

Two multiplexers in front of the function units choose the operands. The first operand is either the source register or the zero-extended 16-bit immediate, so one move code serves both the register and the immediate form. When the instruction is a shift, the second operand is not the second register value. It is the low five bits of that register concatenated above the immediate, zero-extended, so the shift count can come from instruction fields.

Every output is registered, and all outputs change on the rising clock edge after the inputs are presented.

Top module: `alu_steer_core`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after it goes low, `result`, `wr_en` and `ovf` are all 0.
- R2: Function code 0001 gives (A + B) mod 2^32 and code 0010 gives (A - B) mod 2^32, where A and B are the steered operands.
- R3: `ovf` is 1 only for codes 0001 and 0010, and only on two's-complement signed overflow. An example is 0x7FFFFFFF + 1. For all other codes `ovf` is 0.
- R4: Code 0011 gives A AND B, 0100 gives A OR B, 0101 gives A XOR B, and 0110 gives NOT A. Each is applied bitwise.
- R5: Code 0111 compares A and B as unsigned values. The result is {29'b0, A>B, A==B, A<B}.
- R6: Codes 1000, 1001, 1010 and 1011 are logical right, logical left, arithmetic right and arithmetic left shifts of A by an unsigned count equal to B. Arithmetic right fills with A[31] and arithmetic left fills with A[0]. A count of 32 or more fills every bit.
- R7: Operand A is the zero-extended `imm` when `use_imm` is 1, and `src_val` otherwise.
- R8: Operand B is {11'b0, `rt_val[4:0]`, `imm`} when `is_shift` is 1, and `rt_val` otherwise.
- R9: Code 1101 (move) gives A and code 1100 (pass) gives B.
- R10: `wr_en` is 0 for codes 0000, 0111, 1110 and 1111, and 1 for every other code. Codes 0000, 1110 and 1111 give a result of 0.
- R11: `result`, `wr_en` and `ovf` show the operation presented at the inputs on the rising edge that precedes them, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_val | input | 32 | Source register value |
| rt_val | input | 32 | Second register value; its low 5 bits form part of the shift count |
| imm | input | 16 | Immediate field of the instruction |
| use_imm | input | 1 | Selects the immediate as operand A |
| is_shift | input | 1 | Replaces operand B with the concatenated shift count |
| func | input | 4 | Function code |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Registered register-file write enable |
| ovf | output | 1 | Registered signed overflow for add and subtract |

## Verification
Each result, write-enable and overflow value is due exactly one rising edge after its inputs are applied. The bench drives new inputs on the falling edge, lets one rising edge pass, and samples one nanosecond after that edge. At that point it compares against a behavioural model evaluated from the same inputs. Because of this, a missing or extra register stage in any of the three output paths shows up as a mismatch. The directed operands cover the overflow boundaries, shift counts of 0, 31, 32 and counts taken from `rt_val`, all three comparison outcomes, and the unused codes. A block of pseudo-random operands is also run on every code.

// File: rtl/alu_pkg.sv
// Package: shared function codes and width for the steered ALU.
// Assumes: encodings are fixed by the instruction decoder upstream.
package alu_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        FN_NOP  = 4'b0000,
        FN_ADD  = 4'b0001,
        FN_SUB  = 4'b0010,
        FN_AND  = 4'b0011,
        FN_OR   = 4'b0100,
        FN_XOR  = 4'b0101,
        FN_NOT  = 4'b0110,
        FN_CMP  = 4'b0111,
        FN_SRL  = 4'b1000,
        FN_SLL  = 4'b1001,
        FN_SRA  = 4'b1010,
        FN_SLA  = 4'b1011,
        FN_PASS = 4'b1100,
        FN_MOV  = 4'b1101,
        FN_RSV0 = 4'b1110,
        FN_RSV1 = 4'b1111
    } alu_fn_e;
endpackage

// File: rtl/alu_addsub.sv
// Module: ripple-carry adder/subtractor shared by add and subtract.
// Does: sum = a + (b ^ {W{sub}}) + sub; overflow = carry into MSB XOR carry out.
// Assumes: W >= 2; purely combinational.
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W:0]   carry;
    logic [W-1:0] b_eff;

    assign carry[0] = sub;
    assign b_eff    = b ^ {W{sub}};

    // One full-adder cell per bit position, chained through carry.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end

    assign ovf = carry[W] ^ carry[W-1];
endmodule

// File: rtl/alu_cmp.sv
// Module: unsigned ripple magnitude comparator.
// Does: ripples greater/less from LSB to MSB; a higher differing bit overrides.
// Assumes: purely combinational; equal is derived from neither greater nor less.
module alu_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt,
    output logic         eq,
    output logic         lt
);
    logic [W:0] gt_c;
    logic [W:0] lt_c;

    assign gt_c[0] = 1'b0;
    assign lt_c[0] = 1'b0;

    // Each stage decides on its own bit if it differs, else passes the lower verdict.
    for (genvar i = 0; i < W; i++) begin : g_stage
        assign gt_c[i+1] = (a[i] & ~b[i]) | (~(a[i] ^ b[i]) & gt_c[i]);
        assign lt_c[i+1] = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & lt_c[i]);
    end

    assign gt = gt_c[W];
    assign lt = lt_c[W];
    assign eq = ~(gt | lt);
endmodule

// File: rtl/alu_shift.sv
// Module: four-mode shifter with a saturating unsigned count.
// Does: logical/arithmetic, left/right; arithmetic right fills MSB, arithmetic
//       left fills LSB; any count >= W fills the whole word.
// Assumes: count is the full operand B; purely combinational.
module alu_shift #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] cnt,
    input  logic         left,
    input  logic         arith,
    output logic [W-1:0] y
);
    localparam int unsigned SH_W = $clog2(W);

    logic         big;
    logic [SH_W-1:0] n;
    logic         fill;
    logic [W-1:0] fill_mask;
    logic [W-1:0] raw;

    assign big  = (cnt >= W);
    assign n    = cnt[SH_W-1:0];
    assign fill = arith & (left ? a[0] : a[W-1]);

    // Shift the word and build the mask of positions vacated by the shift.
    always_comb begin
        if (left) begin
            raw       = a << n;
            fill_mask = ~({W{1'b1}} << n);
        end else begin
            raw       = a >> n;
            fill_mask = ~({W{1'b1}} >> n);
        end
    end

    // Merge fill bits; saturate when the count covers the whole word.
    always_comb begin
        if (big) y = {W{fill}};
        else     y = raw | (fill ? fill_mask : '0);
    end
endmodule

// File: rtl/alu_steer_core.sv
// Module: top of the steered ALU (execute stage).
// Does: steers operands A/B from register, immediate and shift fields, runs
//       the selected function, registers result, write enable and overflow.
// Assumes: synchronous active-low reset; one cycle latency; imm zero-extended.
module alu_steer_core
    import alu_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned IMM_W = 16,
    parameter int unsigned RT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     src_val,
    input  logic [W-1:0]     rt_val,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             is_shift,
    input  logic [FUNC_W-1:0] func,
    output logic [W-1:0]     result,
    output logic             wr_en,
    output logic             ovf
);
    localparam int unsigned SHCAT_W = RT_W + IMM_W;

    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [W-1:0] sum;
    logic         add_ovf;
    logic         is_sub;
    logic         c_gt, c_eq, c_lt;
    logic [W-1:0] sh_y;
    logic [W-1:0] nxt_res;
    logic         nxt_we;
    logic         nxt_ovf;
    alu_fn_e      fn;

    assign fn = alu_fn_e'(func);

    // Operand A: register source or zero-extended immediate.
    assign op_a = use_imm ? W'(imm) : src_val;

    // Operand B: shift count from {rt, imm} on shifts, else the second register.
    assign op_b = is_shift ? W'({rt_val[RT_W-1:0], imm}) : rt_val;

    assign is_sub = (fn == FN_SUB);

    alu_addsub #(.W(W)) u_addsub (
        .a   (op_a),
        .b   (op_b),
        .sub (is_sub),
        .sum (sum),
        .ovf (add_ovf)
    );

    alu_cmp #(.W(W)) u_cmp (
        .a  (op_a),
        .b  (op_b),
        .gt (c_gt),
        .eq (c_eq),
        .lt (c_lt)
    );

    alu_shift #(.W(W)) u_shift (
        .a     (op_a),
        .cnt   (op_b),
        .left  (func[0]),
        .arith (func[1]),
        .y     (sh_y)
    );

    // Result select, write enable and overflow qualification per function code.
    always_comb begin
        nxt_res = '0;
        nxt_we  = 1'b1;
        nxt_ovf = 1'b0;
        unique case (fn)
            FN_ADD, FN_SUB: begin
                nxt_res = sum;
                nxt_ovf = add_ovf;
            end
            FN_AND:  nxt_res = op_a & op_b;
            FN_OR:   nxt_res = op_a | op_b;
            FN_XOR:  nxt_res = op_a ^ op_b;
            FN_NOT:  nxt_res = ~op_a;
            FN_CMP: begin
                nxt_res = {{(W-3){1'b0}}, c_gt, c_eq, c_lt};
                nxt_we  = 1'b0;
            end
            FN_SRL, FN_SLL, FN_SRA, FN_SLA: nxt_res = sh_y;
            FN_PASS: nxt_res = op_b;
            FN_MOV:  nxt_res = op_a;
            default: nxt_we  = 1'b0;
        endcase
    end

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            result <= nxt_res;
            wr_en  <= nxt_we;
            ovf    <= nxt_ovf;
        end
    end

    // Unused upper rt bits are only consumed on the non-shift path.
    if (SHCAT_W > W) begin : g_bad_width
        initial $error("shift concatenation wider than data path");
    end
endmodule

// File: rtl/alu_steer_chk.sv
// Module: assertion checker for alu_steer_core, attached by bind.
// Does: checks port-level timing relations of write enable, overflow,
//       compare encoding and move steering one cycle after the inputs.
module alu_steer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] src_val,
    input logic [15:0] imm,
    input logic        use_imm,
    input logic [3:0]  func,
    input logic [31:0] result,
    input logic        wr_en,
    input logic        ovf
);
    AST_WE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b0000 || func == 4'b0111 || func[3:1] == 3'b111) |=> !wr_en); // R10

    AST_WE_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (func != 4'b0000 && func != 4'b0111 && func[3:1] != 3'b111) |=> wr_en); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(func == 4'b0001 || func == 4'b0010) |=> !ovf); // R3

    AST_CMP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b0111) |=> ($onehot(result[2:0]) && result[31:3] == '0)); // R5

    AST_MOV_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b1101 && use_imm) |=> (result == {16'h0, $past(imm)})); // R7

    AST_MOV_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b1101 && !use_imm) |=> (result == $past(src_val))); // R9
endmodule

bind alu_steer_core alu_steer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_val (src_val),
    .imm     (imm),
    .use_imm (use_imm),
    .func    (func),
    .result  (result),
    .wr_en   (wr_en),
    .ovf     (ovf)
);

// File: tb/sim_alu_steer_core.sv
// Bench: drives each operation, computes the expected registered outputs
// from a behavioural model, and compares one rising edge later.
module sim_alu_steer_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0;
    logic        is_shift = 1'b0;
    logic [3:0]  func = '0;
    logic [31:0] result;
    logic        wr_en;
    logic        ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    alu_steer_core u0 (
        .clk(clk), .rst_n(rst_n), .src_val(src_val), .rt_val(rt_val),
        .imm(imm), .use_imm(use_imm), .is_shift(is_shift), .func(func),
        .result(result), .wr_en(wr_en), .ovf(ovf)
    );

    // Behavioural reference of one operation.
    function automatic void model(input logic [31:0] s, input logic [31:0] r,
                                  input logic [15:0] im, input bit ui, input bit sh,
                                  input logic [3:0] f, output logic [31:0] er,
                                  output bit ew, output bit eo);
        longint unsigned a, b, n, t;
        a = ui ? longint'(im) : longint'(s);
        b = sh ? ((longint'(r[4:0]) << 16) | longint'(im)) : longint'(r);
        er = '0; ew = 1'b1; eo = 1'b0;
        case (f)
            4'd1: begin t = (a + b) & 64'hFFFF_FFFF; er = t[31:0];
                        eo = (a[31] == b[31]) && (t[31] != a[31]); end
            4'd2: begin t = (a - b) & 64'hFFFF_FFFF; er = t[31:0];
                        eo = (a[31] != b[31]) && (t[31] != a[31]); end
            4'd3: er = 32'(a & b);
            4'd4: er = 32'(a | b);
            4'd5: er = 32'(a ^ b);
            4'd6: er = ~a[31:0];
            4'd7: begin er = {29'd0, a > b, a == b, a < b}; ew = 1'b0; end
            4'd8, 4'd9, 4'd10, 4'd11: begin
                n = b;
                if (n >= 32) begin
                    if (f == 4'd10) er = {32{a[31]}};
                    else if (f == 4'd11) er = {32{a[0]}};
                    else er = '0;
                end else if (f == 4'd8) er = 32'(a >> n);
                else if (f == 4'd9) er = 32'(a << n);
                else if (f == 4'd10) er = 32'($signed(a[31:0]) >>> n);
                else er = 32'((a << n) | (a[0] ? ((64'd1 << n) - 1) : 64'd0));
            end
            4'd12: er = b[31:0];
            4'd13: er = a[31:0];
            default: ew = 1'b0;
        endcase
    endfunction

    // Present one operation, wait one rising edge, compare all outputs.
    task automatic run(input string tag, input logic [31:0] s, input logic [31:0] r,
                       input logic [15:0] im, input bit ui, input bit sh,
                       input logic [3:0] f);
        logic [31:0] er; bit ew, eo;
        @(negedge clk);
        src_val = s; rt_val = r; imm = im; use_imm = ui; is_shift = sh; func = f;
        model(s, r, im, ui, sh, f, er, ew, eo);
        @(posedge clk); #1;
        n_tests++;
        if (result !== er || wr_en !== ew || ovf !== eo) begin
            n_fail++;
            $display("FAIL %s func=%b: got res=%h we=%b ovf=%b, expected res=%h we=%b ovf=%b",
                     tag, f, result, wr_en, ovf, er, ew, eo);
        end
    endtask

    initial begin
        #50000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset with a live operation at the inputs.
        func = 4'd1; src_val = 32'h7FFF_FFFF; rt_val = 32'd1;
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if (result !== 32'd0 || wr_en !== 1'b0 || ovf !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got res=%h we=%b ovf=%b, expected 0 0 0", result, wr_en, ovf);
        end
        @(negedge clk); rst_n = 1'b1;

        // R2 / R3 / R11: add and subtract, overflow boundaries.
        run("R2",  32'd10, 32'd15, 16'h0, 0, 0, 4'd1);
        run("R3",  32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 4'd1);
        run("R3",  32'h8000_0000, 32'h8000_0000, 16'h0, 0, 0, 4'd1);
        run("R2",  32'd10, 32'd15, 16'h0, 0, 0, 4'd2);
        run("R2",  32'hFFFF_FFFF, 32'd1, 16'h0, 0, 0, 4'd2);
        run("R3",  32'h8000_0000, 32'd1, 16'h0, 0, 0, 4'd2);
        run("R11", 32'hFFFF_FFFF, 32'd1, 16'h0, 0, 0, 4'd1);
        // R4: bitwise units.
        run("R4", 32'hA5A5_0F0F, 32'hFFFF_FFFF, 16'h0, 0, 0, 4'd3);
        run("R4", 32'h1234_5678, 32'h0, 16'h0, 0, 0, 4'd4);
        run("R4", 32'hF0F0_F0F0, 32'hFFFF_FFFF, 16'h0, 0, 0, 4'd5);
        run("R4", 32'h0000_FFFF, 32'h0, 16'h0, 0, 0, 4'd6);
        // R5: compare outcomes, unsigned.
        run("R5", 32'd15, 32'd10, 16'h0, 0, 0, 4'd7);
        run("R5", 32'd10, 32'd10, 16'h0, 0, 0, 4'd7);
        run("R5", 32'd10, 32'hFFFF_FFFF, 16'h0, 0, 0, 4'd7);
        // R6 / R8: shift counts from imm and from rt.
        run("R6", 32'hFFFF_FFFF, 32'h0, 16'd31, 0, 1, 4'd8);
        run("R6", 32'h8000_0001, 32'h0, 16'd0, 0, 1, 4'd10);
        run("R6", 32'h8000_0000, 32'h0, 16'd4, 0, 1, 4'd10);
        run("R6", 32'h0000_0001, 32'h0, 16'd4, 0, 1, 4'd11);
        run("R6", 32'h0000_0001, 32'h0, 16'd32, 0, 1, 4'd11);
        run("R6", 32'h1234_5678, 32'h0, 16'd32, 0, 1, 4'd9);
        run("R8", 32'h8000_0000, 32'h0000_00E1, 16'd0, 0, 1, 4'd10);
        run("R8", 32'h0000_00FF, 32'd3, 16'h0, 0, 0, 4'd9);
        // R7 / R9: move forms and pass.
        run("R9", 32'hDEAD_BEEF, 32'h0, 16'h1234, 0, 0, 4'd13);
        run("R7", 32'hDEAD_BEEF, 32'h0, 16'hBEEF, 1, 0, 4'd13);
        run("R9", 32'h0, 32'hCAFE_F00D, 16'h0, 0, 0, 4'd12);
        run("R8", 32'h0, 32'hCAFE_F00D, 16'h5555, 0, 1, 4'd12);
        run("R7", 32'hFFFF_FFFF, 32'd1, 16'hFFFF, 1, 0, 4'd1);
        // R10: suppressed write enable codes.
        run("R10", 32'd5, 32'd6, 16'h0, 0, 0, 4'd0);
        run("R10", 32'd5, 32'd6, 16'h0, 0, 0, 4'd14);
        run("R10", 32'd5, 32'd6, 16'h0, 0, 0, 4'd15);
        // R11: back-to-back random operations across all codes.
        for (int i = 0; i < 400; i++) begin
            run("R11", $urandom, $urandom, 16'($urandom), 1'($urandom),
                1'($urandom), 4'(i % 16));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule